// File: doc/BRIEF.md
# Dual-Protocol Host Bus Bridge

This block connects an asynchronous external microprocessor bus to a 32-bit internal register port. A strapping input chooses between two handshake styles. The first uses separate read and write strobes and a ready output. The second uses a read/write select line, a data strobe and a data-acknowledge output. The same two control pins serve both styles. A chip select qualifies every access. The control pins pass through a two-flop synchronizer before the handshake state machine sees them.

A second input picks 16-bit word transfers or 8-bit byte transfers, and it may change between accesses. The low two address bits, taken with that input, select which half-word or byte of the internal dword appears on the external data pins. Every write is a read-modify-write of the addressed dword, so only the selected lanes change. The internal register file sits outside the block. It takes one read or write strobe and returns read data one cycle after a read strobe.

Top module: `host_bus_bridge`

## Requirements
- R1: With `proto_sel` high, `ctl_a_n` low is a write and `ctl_b_n` low is a read. Each is qualified by `cs_n` low.
- R2: With `proto_sel` low, `ctl_b_n` low is the data strobe and `ctl_a_n` selects the direction: high means read, low means write. Each is qualified by `cs_n` low.
- R3: A strobe while `cs_n` is high starts no internal access, changes no register and raises no acknowledge.
- R4: With `wide_sel` high, `addr[1]` picks the lane: 0 maps to internal bits 15:0 and 1 maps to bits 31:16.
- R5: With `wide_sel` low, `addr[1:0]` picks byte n = bits 8n+7:8n. The byte appears on `data_o[7:0]`, and `data_oe_hi` stays low.
- R6: A write reads the addressed dword first (`reg_rd`), then writes it back on the next cycle (`reg_wr`), changing only the selected bytes.
- R7: `data_oe_lo` is high only while `cs_n` is low and a read is being strobed on the pins. It stays low during writes.
- R8: With `proto_sel` high, `hs_o` (ready) is low from the moment a qualified strobe asserts until the data is valid. It is high otherwise.
- R9: With `proto_sel` low, `hs_o` (data-acknowledge, active low) stays high until the transfer completes. It then stays low until the strobe is released.
- R10: A strobe held asserted after the acknowledge causes exactly one internal access. A new access needs the strobe to be released first.
- R11: `wide_sel` may differ from one access to the next, and each access uses its own setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| proto_sel | input | 1 | Strap: 1 selects separate-strobe handshake, 0 selects data-strobe handshake |
| wide_sel | input | 1 | 1 selects 16-bit transfers, 0 selects 8-bit transfers |
| cs_n | input | 1 | Active-low chip select |
| ctl_a_n | input | 1 | Write strobe (mode 1) or read/write select (mode 0) |
| ctl_b_n | input | 1 | Read strobe (mode 1) or data strobe (mode 0) |
| addr | input | AW | External byte address |
| data_i | input | 16 | External write data |
| data_o | output | 16 | External read data |
| data_oe_lo | output | 1 | Drive enable for data_o[7:0] |
| data_oe_hi | output | 1 | Drive enable for data_o[15:8] |
| hs_o | output | 1 | Ready (mode 1) or active-low data-acknowledge (mode 0) |
| reg_addr | output | AW-2 | Internal dword address |
| reg_rd | output | 1 | Internal read strobe, data returned the next cycle |
| reg_wr | output | 1 | Internal write strobe |
| reg_wdata | output | 32 | Internal write data |
| reg_rdata | input | 32 | Internal read data |

## Verification
The bench drives word and byte accesses in both handshake modes. Each access targets a dword preloaded with distinct bytes, so any lane that is misrouted or clobbered shows up as a wrong byte value. Byte writes at different offsets, followed by reads at other offsets, separate the byte-enable merge from the read steering. Alternating `wide_sel` between accesses to the same dword shows that each access uses its own width. A strobe without chip select, and a strobe held long after the acknowledge, check that an internal access starts only when it should.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
    localparam int EXT_W  = 16;
    localparam int INT_W  = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = INT_W / BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_MERGE,
        ST_ACK
    } hbb_state_e;
endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
    parameter int              W    = 3,
    parameter logic [W-1:0]    INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= INIT;
            stage2_q <= INIT;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/hbb_decode.sv
module hbb_decode (
    input  logic proto_sel,
    input  logic cs_n,
    input  logic ctl_a_n,
    input  logic ctl_b_n,
    output logic sel,
    output logic stb,
    output logic is_read
);
    always_comb begin
        sel = !cs_n;
        if (proto_sel) begin
            stb     = !ctl_a_n || !ctl_b_n;
            is_read = !ctl_b_n;
        end else begin
            stb     = !ctl_b_n;
            is_read = ctl_a_n;
        end
    end
endmodule

// File: rtl/hbb_lane.sv
module hbb_lane
    import hbb_pkg::*;
(
    input  logic [INT_W-1:0] dword_i,
    input  logic             wide,
    input  logic [1:0]       lane_a,
    input  logic [EXT_W-1:0] wdata_i,
    output logic [EXT_W-1:0] rdata_o,
    output logic [INT_W-1:0] merged_o,
    output logic [LANES-1:0] be_o
);
    logic [INT_W-1:0] src;

    always_comb begin
        if (wide) begin
            be_o    = lane_a[1] ? 4'b1100 : 4'b0011;
            src     = {wdata_i, wdata_i};
            rdata_o = lane_a[1] ? dword_i[31:16] : dword_i[15:0];
        end else begin
            be_o    = 4'b0001 << lane_a;
            src     = {LANES{wdata_i[BYTE_W-1:0]}};
            rdata_o = {{(EXT_W-BYTE_W){1'b0}}, dword_i[lane_a*BYTE_W +: BYTE_W]};
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged_o[g*BYTE_W +: BYTE_W] =
            be_o[g] ? src[g*BYTE_W +: BYTE_W] : dword_i[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/host_bus_bridge.sv
module host_bus_bridge
    import hbb_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             proto_sel,
    input  logic             wide_sel,
    input  logic             cs_n,
    input  logic             ctl_a_n,
    input  logic             ctl_b_n,
    input  logic [AW-1:0]    addr,
    input  logic [15:0]      data_i,
    output logic [15:0]      data_o,
    output logic             data_oe_lo,
    output logic             data_oe_hi,
    output logic             hs_o,
    output logic [AW-3:0]    reg_addr,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [31:0]      reg_wdata,
    input  logic [31:0]      reg_rdata
);
    localparam int SYNC_W = 3;

    typedef struct packed {
        hbb_state_e       st;
        logic [AW-1:0]    addr;
        logic             wide;
        logic             rd;
        logic [EXT_W-1:0] wdata;
        logic [INT_W-1:0] rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic [SYNC_W-1:0] ctl_s;
    logic sel_s, stb_s, read_s;
    logic sel_p, stb_p, read_p;
    logic [EXT_W-1:0] lane_rd;
    logic [INT_W-1:0] merged;
    logic [LANES-1:0] be_unused;
    logic busy;

    hbb_sync #(.W(SYNC_W), .INIT('1)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({cs_n, ctl_a_n, ctl_b_n}),
        .sync_o (ctl_s)
    );

    hbb_decode i_dec_sync (
        .proto_sel(proto_sel),
        .cs_n     (ctl_s[2]),
        .ctl_a_n  (ctl_s[1]),
        .ctl_b_n  (ctl_s[0]),
        .sel      (sel_s),
        .stb      (stb_s),
        .is_read  (read_s)
    );

    hbb_decode i_dec_pin (
        .proto_sel(proto_sel),
        .cs_n     (cs_n),
        .ctl_a_n  (ctl_a_n),
        .ctl_b_n  (ctl_b_n),
        .sel      (sel_p),
        .stb      (stb_p),
        .is_read  (read_p)
    );

    hbb_lane i_lane (
        .dword_i (r_q.st == ST_MERGE ? reg_rdata : r_q.rdata),
        .wide    (r_q.wide),
        .lane_a  (r_q.addr[1:0]),
        .wdata_i (r_q.wdata),
        .rdata_o (lane_rd),
        .merged_o(merged),
        .be_o    (be_unused)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (stb_s && sel_s) begin
                    r_d.st    = ST_ACCESS;
                    r_d.addr  = addr;
                    r_d.wide  = wide_sel;
                    r_d.rd    = read_s;
                    r_d.wdata = data_i;
                end
            end
            ST_ACCESS: r_d.st = ST_MERGE;
            ST_MERGE: begin
                r_d.rdata = reg_rdata;
                r_d.st    = ST_ACK;
            end
            ST_ACK: begin
                if (!stb_s) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st == ST_ACCESS) || (r_q.st == ST_MERGE) ||
                  ((r_q.st == ST_IDLE) && stb_p && sel_p);

    assign hs_o       = proto_sel ? !busy : (r_q.st != ST_ACK);
    assign data_oe_lo = sel_p && stb_p && read_p;
    assign data_oe_hi = data_oe_lo && wide_sel;
    assign data_o     = lane_rd;
    assign reg_addr   = r_q.addr[AW-1:2];
    assign reg_rd     = (r_q.st == ST_ACCESS);
    assign reg_wr     = (r_q.st == ST_MERGE) && !r_q.rd;
    assign reg_wdata  = merged;
endmodule

// File: rtl/hbb_checker.sv
module hbb_checker (
    input logic clk,
    input logic rst_n,
    input logic proto_sel,
    input logic cs_n,
    input logic reg_rd,
    input logic reg_wr,
    input logic hs_o,
    input logic data_oe_lo,
    input logic data_oe_hi
);
    a_r6_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(reg_rd));

    a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    a_r8_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_sel && reg_rd) |-> !hs_o);

    a_r9_ack_high_writing: assert property (@(posedge clk) disable iff (!rst_n)
        (!proto_sel && reg_wr) |-> hs_o);

    a_r7_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_lo |-> !cs_n);

    a_r5_hi_needs_lo: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_hi |-> data_oe_lo);

    a_r3_rd_wr_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));
endmodule

bind host_bus_bridge hbb_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .proto_sel (proto_sel),
    .cs_n      (cs_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .hs_o      (hs_o),
    .data_oe_lo(data_oe_lo),
    .data_oe_hi(data_oe_hi)
);

// File: tb/test_host_bus_bridge.sv
`timescale 1ns/1ps
module test_host_bus_bridge;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic proto_sel = 1'b1, wide_sel = 1'b1, cs_n = 1'b1;
    logic ctl_a_n = 1'b1, ctl_b_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0] data_i = '0, data_o;
    logic data_oe_lo, data_oe_hi, hs_o;
    logic [AW-3:0] reg_addr;
    logic reg_rd, reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = '0;

    logic [31:0] mem [64];
    logic pre_we = 1'b0;
    logic [5:0] pre_a = '0;
    logic [31:0] pre_d = '0;
    int rd_cnt = 0, wr_cnt = 0;
    int tests = 0, fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    host_bus_bridge #(.AW(AW)) i_host_bus_bridge (
        .clk(clk), .rst_n(rst_n), .proto_sel(proto_sel), .wide_sel(wide_sel),
        .cs_n(cs_n), .ctl_a_n(ctl_a_n), .ctl_b_n(ctl_b_n), .addr(addr),
        .data_i(data_i), .data_o(data_o), .data_oe_lo(data_oe_lo),
        .data_oe_hi(data_oe_hi), .hs_o(hs_o), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_rd) begin
            reg_rdata <= mem[reg_addr];
            rd_cnt <= rd_cnt + 1;
        end
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (pre_we) mem[pre_a] <= pre_d;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic poke(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        pre_a = a; pre_d = d; pre_we = 1'b1;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // one host access; returns data and enables seen at the handshake
    task automatic host(input string req, input logic rd, input logic wide,
                        input logic [AW-1:0] a, input logic [15:0] wd,
                        output logic [15:0] q, output logic oe_lo, output logic oe_hi);
        int n;
        @(negedge clk);
        addr = a; wide_sel = wide; data_i = wd; cs_n = 1'b0;
        if (proto_sel) begin
            if (rd) ctl_b_n = 1'b0; else ctl_a_n = 1'b0;
        end else begin
            ctl_a_n = rd;
            #1 ctl_b_n = 1'b0;
        end
        #1;
        chk({req, " handshake pending"}, hs_o, proto_sel ? 1'b0 : 1'b1);
        if (!rd) chk({req, " R7 no drive on write"}, data_oe_lo, 1'b0);
        n = 0;
        while (hs_o !== proto_sel && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk({req, " handshake reached"}, hs_o, proto_sel);
        q = data_o; oe_lo = data_oe_lo; oe_hi = data_oe_hi;
        ctl_a_n = 1'b1; ctl_b_n = 1'b1; cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk({req, " handshake released"}, hs_o, 1'b1);
    endtask

    task automatic t_reset();
        chk("R8 reset ready high", hs_o, 1'b1);
        chk("R7 reset no drive", {data_oe_hi, data_oe_lo}, 2'b00);
        chk("R6 reset no access", {reg_rd, reg_wr}, 2'b00);
    endtask

    task automatic t_sep_word();
        logic [15:0] q; logic lo, hi;
        poke(6'd3, 32'h11223344);
        host("R1 R4 word write hi", 1'b0, 1'b1, 8'h0E, 16'hBEEF, q, lo, hi);
        chk("R6 R4 merged hi half", mem[3], 32'hBEEF3344);
        host("R1 word read lo", 1'b1, 1'b1, 8'h0C, 16'h0, q, lo, hi);
        chk("R4 low half data", q, 16'h3344);
        chk("R7 word read enables", {hi, lo}, 2'b11);
        host("R1 word read hi", 1'b1, 1'b1, 8'h0E, 16'h0, q, lo, hi);
        chk("R4 high half data", q, 16'hBEEF);
    endtask

    task automatic t_sep_byte();
        logic [15:0] q; logic lo, hi;
        poke(6'd5, 32'hA0B0C0D0);
        host("R5 byte write", 1'b0, 1'b0, 8'h15, 16'hFF5A, q, lo, hi);
        chk("R6 byte merge", mem[5], 32'hA0B05AD0);
        host("R5 byte read 3", 1'b1, 1'b0, 8'h17, 16'h0, q, lo, hi);
        chk("R5 byte 3 data", q, 16'h00A0);
        chk("R5 upper lane undriven", {hi, lo}, 2'b01);
        host("R11 word after byte", 1'b1, 1'b1, 8'h16, 16'h0, q, lo, hi);
        chk("R11 word width used", q, 16'hA0B0);
        host("R11 byte after word", 1'b1, 1'b0, 8'h15, 16'h0, q, lo, hi);
        chk("R11 byte width used", q, 16'h005A);
    endtask

    task automatic t_cs_gate();
        int r0, w0;
        poke(6'd7, 32'h55555555);
        r0 = rd_cnt; w0 = wr_cnt;
        @(negedge clk);
        addr = 8'h1C; data_i = 16'h0; wide_sel = 1'b1; cs_n = 1'b1;
        ctl_a_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 ready stays high", hs_o, 1'b1);
        ctl_a_n = 1'b1; ctl_b_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 R7 no drive without cs", data_oe_lo, 1'b0);
        ctl_b_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3 no internal access", rd_cnt - r0 + wr_cnt - w0, 0);
        chk("R3 register unchanged", mem[7], 32'h55555555);
    endtask

    task automatic t_hold();
        int r0, n;
        poke(6'd8, 32'h0BADF00D);
        r0 = rd_cnt;
        @(negedge clk);
        addr = 8'h20; wide_sel = 1'b1; cs_n = 1'b0; ctl_b_n = 1'b0;
        n = 0;
        while (hs_o !== 1'b1 && n < 50) begin @(negedge clk); n++; end
        repeat (20) @(negedge clk);
        chk("R10 one access while held", rd_cnt - r0, 1);
        chk("R10 data held", data_o, 16'hF00D);
        ctl_b_n = 1'b1; cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_moto();
        logic [15:0] q; logic lo, hi;
        proto_sel = 1'b0;
        do_reset();
        chk("R9 idle ack high", hs_o, 1'b1);
        poke(6'd9, 32'h01020304);
        host("R2 R9 byte write", 1'b0, 1'b0, 8'h26, 16'h0077, q, lo, hi);
        chk("R2 R6 byte merge", mem[9], 32'h01770304);
        host("R2 R9 word write", 1'b0, 1'b1, 8'h24, 16'hCAFE, q, lo, hi);
        chk("R2 R4 word merge", mem[9], 32'h0177CAFE);
        host("R2 word read", 1'b1, 1'b1, 8'h26, 16'h0, q, lo, hi);
        chk("R2 R4 word data", q, 16'h0177);
        host("R2 byte read", 1'b1, 1'b0, 8'h27, 16'h0, q, lo, hi);
        chk("R2 R5 byte data", q, 16'h0001);
        chk("R5 R7 byte enables", {hi, lo}, 2'b01);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_sep_word();
        t_sep_byte();
        t_cs_gate();
        t_hold();
        t_moto();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule